// File: doc/BRIEF.md
# Overlapped Multi-Width Register File

This block holds the general-purpose registers of a 16-bit processor core: sixteen 16-bit words. The same words can be viewed at four widths. The byte view reaches only the lower eight words. The word view reaches each word on its own. The long view pairs two adjacent words into 32 bits. The quad view groups four words into 64 bits. One write port and two independent read ports each take a size selector and a 4-bit index. The block maps the index onto the words it covers, merges partial writes into the stored word and returns read data right-aligned.

The top word, index 15, serves as the stack pointer. It is kept in two physical copies, one for system mode and one for normal mode. The mode input selects which copy every view sees, for both reads and writes. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `gpr_overlay_file`

## Requirements
- R1: An active-low asynchronous reset clears all sixteen words and both stack-pointer copies to zero.
- R2: The size code is 0 for byte, 1 for word, 2 for long and 3 for quad. A word access at index i reads or writes word i in bits 15:0, and the read data carries zeros above bit 15.
- R3: Byte index n selects word n>>1. An even n selects bits 15:8 of that word and an odd n selects bits 7:0. Read data holds the byte in bits 7:0 with zeros above, and a byte write takes its value from write bits 7:0.
- R4: A byte write leaves the other byte of the same word unchanged.
- R5: A long access at index k uses base word k with bit 0 cleared. The base word sits in bits 31:16 and the next word in bits 15:0. An odd index is treated as the even index below it.
- R6: A quad access at index q uses base word q with bits 1:0 cleared. Words base to base+3 occupy bits 63:48, 47:32, 31:16 and 15:0 in that order.
- R7: Word 15 exists in two copies. When sys_mode is 1 the system copy is used, and when it is 0 the normal copy is used. This applies to word, long and quad accesses alike, and a write never changes the copy that is not selected.
- R8: A write happens only at a rising clock edge with wr_en high. With wr_en low, no stored value changes.
- R9: Both read ports are combinational and independent. A read of a location being written in the same cycle returns the value from before the edge.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_mode | input | 1 | 1 selects the system stack-pointer copy, 0 the normal copy |
| wr_en | input | 1 | Write enable |
| wr_size | input | 2 | Write size code |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 64 | Write data, right-aligned |
| ra_size | input | 2 | Read port A size code |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | 64 | Read port A data, right-aligned |
| rb_size | input | 2 | Read port B size code |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | 64 | Read port B data, right-aligned |

## Verification
A fault in the index mapping or the lane merge puts bytes or words in the wrong place. This shows on the next read through any view that overlaps the damaged word, one cycle after the write edge. A fault in the stack-pointer banking shows as soon as the mode input flips, because the read ports follow the mode combinationally. The bench therefore writes through one view and reads back through a different one, and it toggles the mode between writes and reads of word 15. A same-cycle write and read exposes any bypass that should not be there.

// File: rtl/gpr_overlay_file.sv
`timescale 1ns/1ps
module gpr_overlay_file #(
  parameter int NWORDS = 16,
  parameter int WW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_size,
  input  logic [3:0]    wr_idx,
  input  logic [63:0]   wr_data,
  input  logic [1:0]    ra_size,
  input  logic [3:0]    ra_idx,
  output logic [63:0]   ra_data,
  input  logic [1:0]    rb_size,
  input  logic [3:0]    rb_idx,
  output logic [63:0]   rb_data
);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
  localparam int         SP_IDX  = NWORDS - 1;

  logic [NWORDS-1:0][WW-1:0] gpr;
  logic [WW-1:0]             sp_sys;
  logic [NWORDS-1:0][WW-1:0] view;
  logic [NWORDS-1:0][WW-1:0] nval;
  logic [NWORDS-1:0]         hit;

  always_comb begin
    view = gpr;
    if (sys_mode) view[SP_IDX] = sp_sys;
  end

  always_comb begin
    logic [3:0] b;
    logic [3:0] bw;
    hit  = '0;
    nval = view;
    bw   = {1'b0, wr_idx[3:1]};
    b    = '0;
    unique case (wr_size)
      SZ_BYTE: begin
        hit[bw] = 1'b1;
        if (wr_idx[0]) nval[bw] = {view[bw][15:8], wr_data[7:0]};
        else           nval[bw] = {wr_data[7:0], view[bw][7:0]};
      end
      SZ_WORD: begin
        hit[wr_idx]  = 1'b1;
        nval[wr_idx] = wr_data[15:0];
      end
      SZ_LONG: begin
        b = {wr_idx[3:1], 1'b0};
        for (int j = 0; j < 2; j++) begin
          hit[b + 4'(j)]  = 1'b1;
          nval[b + 4'(j)] = wr_data[31-16*j -: 16];
        end
      end
      default: begin
        b = {wr_idx[3:2], 2'b00};
        for (int j = 0; j < 4; j++) begin
          hit[b + 4'(j)]  = 1'b1;
          nval[b + 4'(j)] = wr_data[63-16*j -: 16];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr    <= '0;
      sp_sys <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (hit[i]) begin
          if (i == SP_IDX && sys_mode) sp_sys <= nval[i];
          else                         gpr[i] <= nval[i];
        end
      end
    end
  end

  function automatic logic [63:0] rd_view(input logic [NWORDS-1:0][WW-1:0] v,
                                          input logic [1:0] sz,
                                          input logic [3:0] ix);
    logic [3:0] b;
    rd_view = '0;
    b = '0;
    unique case (sz)
      SZ_BYTE: rd_view[7:0] = ix[0] ? v[{1'b0, ix[3:1]}][7:0]
                                    : v[{1'b0, ix[3:1]}][15:8];
      SZ_WORD: rd_view[15:0] = v[ix];
      SZ_LONG: begin
        b = {ix[3:1], 1'b0};
        rd_view[31:0] = {v[b], v[b | 4'd1]};
      end
      default: begin
        b = {ix[3:2], 2'b00};
        rd_view = {v[b], v[b | 4'd1], v[b | 4'd2], v[b | 4'd3]};
      end
    endcase
  endfunction

  assign ra_data = rd_view(view, ra_size, ra_idx);
  assign rb_data = rd_view(view, rb_size, rb_idx);
endmodule

// File: rtl/gpr_overlay_file_chk.sv
`timescale 1ns/1ps
module gpr_overlay_file_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_mode,
  input logic              wr_en,
  input logic [1:0]        wr_size,
  input logic [3:0]        wr_idx,
  input logic [15:0]       wr_lo,
  input logic [1:0]        ra_size,
  input logic [63:0]       ra_data,
  input logic [15:0][15:0] gpr,
  input logic [15:0]       sp_sys
);
  logic [3:0]  bw;
  logic [15:0] bw_old;
  assign bw     = {1'b0, wr_idx[3:1]};
  assign bw_old = gpr[bw];

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(gpr) && $stable(sp_sys)));

  a_r7_sys_keeps_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sys_mode) |=> $stable(gpr[15]));

  a_r7_normal_keeps_sys: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sys_mode) |=> $stable(sp_sys));

  a_r4_even_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd0 && !wr_idx[0]) |=> (gpr[$past(bw)][7:0] == $past(bw_old[7:0])));

  a_r4_odd_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd0 && wr_idx[0]) |=> (gpr[$past(bw)][15:8] == $past(bw_old[15:8])));

  a_r2_word_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'd1 && wr_idx != 4'd15) |=> (gpr[$past(wr_idx)] == $past(wr_lo)));

  a_r3_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_size == 2'd0) |-> (ra_data[63:8] == 56'd0));
endmodule

bind gpr_overlay_file gpr_overlay_file_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .wr_en(wr_en),
  .wr_size(wr_size), .wr_idx(wr_idx), .wr_lo(wr_data[15:0]),
  .ra_size(ra_size), .ra_data(ra_data), .gpr(gpr), .sp_sys(sp_sys)
);

// File: tb/tb_gpr_overlay_file.sv
`timescale 1ns/1ps
module tb_gpr_overlay_file;
  logic clk = 1'b0, rst_n = 1'b0, sys_mode = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_size = '0, ra_size = '0, rb_size = '0;
  logic [3:0] wr_idx = '0, ra_idx = '0, rb_idx = '0;
  logic [63:0] wr_data = '0, ra_data, rb_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpr_overlay_file dut (
    .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .wr_en(wr_en),
    .wr_size(wr_size), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_size(ra_size), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_size(rb_size), .rb_idx(rb_idx), .rb_data(rb_data)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        md;
    logic [1:0]  ws;
    logic [3:0]  wi;
    logic [63:0] wd;
    logic [1:0]  rs;
    logic [3:0]  ri;
    logic [63:0] ex;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{4'd2, 1'b1, 2'd1, 4'd3,  64'h1234,              2'd1, 4'd3,  64'h1234},              // R2
    '{4'd4, 1'b1, 2'd0, 4'd6,  64'hAB,                2'd1, 4'd3,  64'hAB34},              // R3 R4
    '{4'd3, 1'b1, 2'd0, 4'd7,  64'hCD,                2'd0, 4'd7,  64'hCD},                // R3
    '{4'd5, 1'b1, 2'd2, 4'd4,  64'h1111_2222,         2'd2, 4'd4,  64'h1111_2222},         // R5
    '{4'd5, 1'b1, 2'd2, 4'd9,  64'h3333_4444,         2'd1, 4'd9,  64'h4444},              // R5 misaligned
    '{4'd6, 1'b1, 2'd3, 4'd1,  64'h0001_0002_0003_0004, 2'd3, 4'd2, 64'h0001_0002_0003_0004}, // R6
    '{4'd4, 1'b1, 2'd0, 4'd0,  64'hFF,                2'd2, 4'd0,  64'hFF01_0002},         // R4 R3
    '{4'd7, 1'b1, 2'd1, 4'd15, 64'h5A5A,              2'd1, 4'd15, 64'h5A5A},              // R7
    '{4'd7, 1'b0, 2'd1, 4'd14, 64'h7777,              2'd2, 4'd14, 64'h7777_0000},         // R7
    '{4'd7, 1'b0, 2'd1, 4'd15, 64'h0F0F,              2'd3, 4'd12, 64'h0000_0000_7777_0F0F}, // R7
    '{4'd7, 1'b1, 2'd1, 4'd12, 64'hC0DE,              2'd3, 4'd13, 64'hC0DE_0000_7777_5A5A}, // R7 R6
    '{4'd3, 1'b1, 2'd0, 4'd15, 64'h99,                2'd1, 4'd7,  64'h0099}               // R3
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_a(input logic md, input logic [1:0] sz, input logic [3:0] ix);
    sys_mode = md; ra_size = sz; ra_idx = ix; #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state through several views and both modes
    rd_a(1'b1, 2'd3, 4'd0);  chk("R1 quad0", ra_data, 64'h0);
    rd_a(1'b1, 2'd3, 4'd4);  chk("R1 quad4", ra_data, 64'h0);
    rd_a(1'b1, 2'd3, 4'd8);  chk("R1 quad8", ra_data, 64'h0);
    rd_a(1'b1, 2'd3, 4'd12); chk("R1 quad12 sys", ra_data, 64'h0);
    rd_a(1'b0, 2'd3, 4'd12); chk("R1 quad12 normal", ra_data, 64'h0);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sys_mode = TBL[i].md; wr_en = 1'b1;
      wr_size = TBL[i].ws; wr_idx = TBL[i].wi; wr_data = TBL[i].wd;
      @(posedge clk); #1;
      wr_en = 1'b0;
      rd_a(TBL[i].md, TBL[i].rs, TBL[i].ri);
      chk($sformatf("R%0d table row %0d", TBL[i].rq, i), ra_data, TBL[i].ex);
    end

    // R9 same-cycle write and read returns the old value; port B independent
    @(negedge clk);
    sys_mode = 1'b1; wr_en = 1'b1; wr_size = 2'd1; wr_idx = 4'd3; wr_data = 64'hBEEF;
    ra_size = 2'd1; ra_idx = 4'd3; rb_size = 2'd2; rb_idx = 4'd4; #1;
    chk("R9 old value before edge", ra_data, 64'h0004);
    chk("R9 port B long", rb_data, 64'h1111_2222);
    @(posedge clk); #1; wr_en = 1'b0; #1;
    chk("R9 new value after edge", ra_data, 64'hBEEF);

    // R8 idle cycle with garbage on the write bus
    @(negedge clk);
    wr_en = 1'b0; wr_size = 2'd3; wr_idx = 4'd0; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(posedge clk); #1;
    rd_a(1'b1, 2'd3, 4'd0); chk("R8 quad0 unchanged", ra_data, 64'hFF01_0002_0003_BEEF);

    // R7 mode flip exposes each copy
    rd_a(1'b0, 2'd1, 4'd15); chk("R7 normal copy", ra_data, 64'h0F0F);
    rd_a(1'b1, 2'd1, 4'd15); chk("R7 system copy", ra_data, 64'h5A5A);

    // R3 byte views of word 7 and R2 word zero extension
    rd_a(1'b1, 2'd0, 4'd14); chk("R3 byte14 high lane", ra_data, 64'h0);
    rd_a(1'b1, 2'd0, 4'd1);  chk("R3 byte1 low lane", ra_data, 64'h01);
    rd_a(1'b1, 2'd1, 4'd0);  chk("R2 word0", ra_data, 64'hFF01);

    // R1 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    rd_a(1'b1, 2'd3, 4'd12); chk("R1 async clear sys", ra_data, 64'h0);
    rd_a(1'b0, 2'd3, 4'd12); chk("R1 async clear normal", ra_data, 64'h0);
    rd_a(1'b0, 2'd3, 4'd0);  chk("R1 async clear quad0", ra_data, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule